// File: doc/BRIEF.md
# Polled Alarm Reporting and Error Window Counter

This block sits on a line card and links it to a supervisory controller over a serial alarm bus. It latches every on-card alarm input and holds it until the controller has seen it. On a poll request it sends one serial frame. The frame carries the latched alarm word, the two error counts of the last completed one-second window and a parity bit. The controller drives a small set of latched control outputs through a write strobe. These outputs are alarm-signal injection force, protection path select and the front-panel alarm lamp.

A defined subset of alarms is critical: receive injection, transmit injection, line signal failure and auxiliary-2 receive. A new occurrence of any of them raises an urgent request line at once, so the controller does not have to wait for its next poll. The controller clears the line with an acknowledge. Coding violations are counted in one counter. The second counter takes either parity errors or cumulative errors, as a configuration input selects. Both counters run over windows marked by an external one-second sync pulse and saturate at all-ones.

The poll engine has four states: `PS_IDLE`, `PS_START`, `PS_DATA` and `PS_PARITY`. Its transitions are:
- accept (IDLE→START on a poll request)
- begin (START→DATA)
- shift (DATA→DATA while payload bits remain)
- last (DATA→PARITY after the 48th payload bit)
- done (PARITY→IDLE)

The urgent engine has two states, `US_CLEAR` and `US_PENDING`. Its transitions are:
- raise (CLEAR→PENDING on a new critical alarm)
- release (PENDING→CLEAR on an acknowledge with no new critical alarm)
- hold (PENDING stays PENDING otherwise)

Top module: `alarm_poll_link`

## Requirements
- R1: An alarm input bit that is high for even one clock cycle is latched. It is reported as 1 in the next poll frame even if the input has since dropped. Alarm word bit i corresponds to alarm_in[i].
- R2: When a poll is accepted, each latch is reloaded from its current input. A bit whose input is low at acceptance reads 0 in the following frame. A bit whose input is still high reads 1.
- R3: A poll request sampled in idle starts a frame. ser_valid is high for exactly 50 cycles, beginning the cycle after acceptance. The bits are sent in this order:
  - a start bit of 1;
  - the 16-bit alarm word, MSB first;
  - the 16-bit coding-violation count, MSB first;
  - the 16-bit selected-source count, MSB first;
  - a parity bit that makes the 48 payload bits plus parity even.

  ser_out is 0 whenever ser_valid is low.
- R4: A poll request that arrives while a frame is in progress is ignored. No second frame follows.
- R5: A write strobe ctrl_we loads ctrl_wdata, and the new values show on the outputs the next cycle. Bit 0 drives inject_force, bit 1 drives prot_sel and bit 2 drives led_on. Without a strobe the outputs hold. After reset all three are 0.
- R6: The critical alarms are alarm_in bits 0 to 3. A 0→1 change on any of them raises urgent_req on the next cycle. Bits 4 to 15 never raise it.
- R7: urgent_req stays high until urgent_ack is sampled high. It drops the following cycle if no new critical alarm arrives in that cycle.
- R8: A new critical alarm that arrives in the same cycle as urgent_ack keeps urgent_req high.
- R9: Each cv_err pulse counts in the violation counter. The second counter takes par_err when err_src_sel is 0 and cum_err when it is 1. At sec_pulse both counts move to the reported registers and counting restarts. An event in the same cycle as sec_pulse belongs to the new window.
- R10: Error counters saturate at 0xFFFF and do not wrap.
- R11: After reset: ser_valid and ser_out are 0, urgent_req is 0, all latches are 0 and both reported counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alarm_in | input | 16 | On-card alarm inputs, active high |
| poll_req | input | 1 | Controller poll request |
| ser_out | output | 1 | Serial poll frame data |
| ser_valid | output | 1 | High while a frame bit is on ser_out |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control write data |
| inject_force | output | 1 | Latched alarm-signal injection force |
| prot_sel | output | 1 | Latched protection path select |
| led_on | output | 1 | Latched front-panel alarm lamp drive |
| urgent_req | output | 1 | Urgent attention request |
| urgent_ack | input | 1 | Controller acknowledge of urgent request |
| cv_err | input | 1 | Coding violation event pulse |
| par_err | input | 1 | Parity error event pulse |
| cum_err | input | 1 | Cumulative error event pulse |
| err_src_sel | input | 1 | Selects the second count source: 0 parity, 1 cumulative |
| sec_pulse | input | 1 | One-second window sync pulse |

## Verification
A wrong poll state shows within one frame as a wrong ser_valid length, a misplaced start bit or a parity mismatch. A latch that clears too early or too late makes the next frame's alarm word wrong. A corrupted urgent state shows on urgent_req one cycle after the causing alarm or acknowledge. Counter faults, such as wrapping or a misassigned edge event, stay hidden until a later sync pulse and poll bring the counts out. The bench therefore always closes a window and polls before it judges them.

// File: rtl/apl_pkg.sv
package apl_pkg;
    typedef enum logic [1:0] {
        PS_IDLE,
        PS_START,
        PS_DATA,
        PS_PARITY
    } poll_state_e;

    typedef enum logic {
        US_CLEAR,
        US_PENDING
    } urg_state_e;

    localparam int CTRL_INJECT = 0;
    localparam int CTRL_PROT   = 1;
    localparam int CTRL_LED    = 2;
    localparam int CTRL_W      = 3;
endpackage

// File: rtl/apl_alarm_latch.sv
module apl_alarm_latch #(
    parameter int ALARM_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ALARM_W-1:0] alarm_in,
    input  logic               reload,
    output logic [ALARM_W-1:0] latch_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      latch_q <= '0;
        else if (reload) latch_q <= alarm_in;
        else             latch_q <= latch_q | alarm_in;
    end

    // R1
    alarm_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_in != '0) |=> ((latch_q & $past(alarm_in)) == $past(alarm_in)));

    // R1
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
endmodule

// File: rtl/apl_sat_window.sv
module apl_sat_window #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         win_pulse,
    output logic [W-1:0] hold_q
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (win_pulse) begin
            hold_q <= cnt_q;
            cnt_q  <= evt ? W'(1) : '0;
        end else if (evt && cnt_q != CNT_MAX) begin
            cnt_q  <= cnt_q + W'(1);
        end
    end

    // R10
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !win_pulse) |=> (cnt_q == CNT_MAX));

    // R9
    window_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_pulse |=> (hold_q == $past(cnt_q)));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_pulse |=> $stable(hold_q));
endmodule

// File: rtl/apl_urgent_fsm.sv
module apl_urgent_fsm #(
    parameter int               ALARM_W   = 16,
    parameter logic [ALARM_W-1:0] CRIT_MASK = 16'h000F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ALARM_W-1:0] alarm_in,
    input  logic               urgent_ack,
    output logic               urgent_req
);
    import apl_pkg::*;

    urg_state_e         state_q, state_d;
    logic [ALARM_W-1:0] crit_prev_q;
    logic               crit_new;

    assign crit_new = |(alarm_in & CRIT_MASK & ~crit_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= US_CLEAR;
            crit_prev_q <= '0;
        end else begin
            state_q     <= state_d;
            crit_prev_q <= alarm_in & CRIT_MASK;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            US_CLEAR:   if (crit_new) state_d = US_PENDING;
            US_PENDING: if (urgent_ack && !crit_new) state_d = US_CLEAR;
            default:    state_d = US_CLEAR;
        endcase
    end

    assign urgent_req = (state_q == US_PENDING);

    // R6
    urgent_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urgent_req) |-> $past(crit_new));

    // R7
    urgent_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent_req && !urgent_ack) |=> urgent_req);

    // R8
    urgent_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crit_new |=> urgent_req);
endmodule

// File: rtl/apl_poll_fsm.sv
module apl_poll_fsm #(
    parameter int PAYLOAD_W = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 poll_req,
    input  logic [PAYLOAD_W-1:0] payload,
    output logic                 accept,
    output logic                 ser_out,
    output logic                 ser_valid
);
    import apl_pkg::*;

    localparam int CNT_W = $clog2(PAYLOAD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PAYLOAD_W - 1);

    poll_state_e          state_q, state_d;
    logic [PAYLOAD_W-1:0] shreg_q;
    logic [CNT_W-1:0]     bit_cnt_q;
    logic                 par_q;

    assign accept = (state_q == PS_IDLE) && poll_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:   if (poll_req) state_d = PS_START;
            PS_START:  state_d = PS_DATA;
            PS_DATA:   if (bit_cnt_q == LAST_BIT) state_d = PS_PARITY;
            PS_PARITY: state_d = PS_IDLE;
            default:   state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_cnt_q <= '0;
            par_q     <= 1'b0;
        end else if (accept) begin
            shreg_q   <= payload;
            bit_cnt_q <= '0;
            par_q     <= ^payload;
        end else if (state_q == PS_DATA) begin
            shreg_q   <= {shreg_q[PAYLOAD_W-2:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        ser_out   = 1'b0;
        ser_valid = 1'b1;
        unique case (state_q)
            PS_IDLE:   ser_valid = 1'b0;
            PS_START:  ser_out = 1'b1;
            PS_DATA:   ser_out = shreg_q[PAYLOAD_W-1];
            PS_PARITY: ser_out = par_q;
            default:   ser_valid = 1'b0;
        endcase
    end

    // R3 R4
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> $past(poll_req));

    // R3
    data_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DATA) |-> (bit_cnt_q <= LAST_BIT));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> !ser_out);
endmodule

// File: rtl/alarm_poll_link.sv
module alarm_poll_link #(
    parameter int                 ALARM_W   = 16,
    parameter int                 ERR_W     = 16,
    parameter logic [ALARM_W-1:0] CRIT_MASK = 16'h000F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ALARM_W-1:0] alarm_in,
    input  logic               poll_req,
    output logic               ser_out,
    output logic               ser_valid,
    input  logic               ctrl_we,
    input  logic [2:0]         ctrl_wdata,
    output logic               inject_force,
    output logic               prot_sel,
    output logic               led_on,
    output logic               urgent_req,
    input  logic               urgent_ack,
    input  logic               cv_err,
    input  logic               par_err,
    input  logic               cum_err,
    input  logic               err_src_sel,
    input  logic               sec_pulse
);
    import apl_pkg::*;

    localparam int PAYLOAD_W = ALARM_W + 2 * ERR_W;

    logic [ALARM_W-1:0] latch_q;
    logic [ERR_W-1:0]   hold_cnt [2];
    logic [1:0]         evt;
    logic               accept;
    logic [CTRL_W-1:0]  ctrl_q;

    assign evt[0] = cv_err;
    assign evt[1] = err_src_sel ? cum_err : par_err;

    apl_alarm_latch #(.ALARM_W(ALARM_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .alarm_in (alarm_in),
        .reload   (accept),
        .latch_q  (latch_q)
    );

    for (genvar g = 0; g < 2; g++) begin : g_win
        apl_sat_window #(.W(ERR_W)) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt[g]),
            .win_pulse (sec_pulse),
            .hold_q    (hold_cnt[g])
        );
    end

    apl_poll_fsm #(.PAYLOAD_W(PAYLOAD_W)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll_req  (poll_req),
        .payload   ({latch_q, hold_cnt[0], hold_cnt[1]}),
        .accept    (accept),
        .ser_out   (ser_out),
        .ser_valid (ser_valid)
    );

    apl_urgent_fsm #(.ALARM_W(ALARM_W), .CRIT_MASK(CRIT_MASK)) u_urgent (
        .clk        (clk),
        .rst_n      (rst_n),
        .alarm_in   (alarm_in),
        .urgent_ack (urgent_ack),
        .urgent_req (urgent_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    assign inject_force = ctrl_q[CTRL_INJECT];
    assign prot_sel     = ctrl_q[CTRL_PROT];
    assign led_on       = ctrl_q[CTRL_LED];

    // R5
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable({inject_force, prot_sel, led_on}));

    // R5
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ({led_on, prot_sel, inject_force} == $past(ctrl_wdata)));
endmodule

// File: tb/alarm_poll_link_bench.sv
module alarm_poll_link_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] alarm_in = '0;
    logic        poll_req = 1'b0;
    logic        ser_out, ser_valid;
    logic        ctrl_we = 1'b0;
    logic [2:0]  ctrl_wdata = '0;
    logic        inject_force, prot_sel, led_on, urgent_req;
    logic        urgent_ack = 1'b0;
    logic        cv_err = 1'b0, par_err = 1'b0, cum_err = 1'b0;
    logic        err_src_sel = 1'b0, sec_pulse = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [15:0] f_alarm, f_cv, f_sel;
    logic        f_ok;

    always #2 clk = ~clk;

    alarm_poll_link u_alarm_poll_link (
        .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .poll_req(poll_req),
        .ser_out(ser_out), .ser_valid(ser_valid), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .inject_force(inject_force), .prot_sel(prot_sel),
        .led_on(led_on), .urgent_req(urgent_req), .urgent_ack(urgent_ack),
        .cv_err(cv_err), .par_err(par_err), .cum_err(cum_err),
        .err_src_sel(err_src_sel), .sec_pulse(sec_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alarm_in = '0; poll_req = 0; ctrl_we = 0; urgent_ack = 0;
        cv_err = 0; par_err = 0; cum_err = 0; sec_pulse = 0; err_src_sel = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issue a poll and collect one frame; optionally re-poll mid-frame (R4)
    task automatic poll_frame(input bit repoll);
        logic [47:0] pay;
        logic        startb, parb;
        f_ok = 1'b1;
        pay = '0;
        poll_req = 1'b1;
        @(negedge clk);
        poll_req = 1'b0;
        for (int k = 0; k < 50; k++) begin
            if (!ser_valid) f_ok = 1'b0;
            if (k == 0) startb = ser_out;
            else if (k == 49) parb = ser_out;
            else pay = {pay[46:0], ser_out};
            if (repoll && (k == 10 || k == 49)) poll_req = 1'b1;
            @(negedge clk);
            poll_req = 1'b0;
        end
        check("R3 valid length", {31'd0, f_ok}, 32'd1);
        check("R3 start bit", {31'd0, startb}, 32'd1);
        check("R3 even parity", {31'd0, ^{pay, parb}}, 32'd0);
        check("R3 R4 valid drops after frame", {30'd0, ser_valid, ser_out}, 32'd0);
        if (repoll) begin
            repeat (3) begin
                @(negedge clk);
                check("R4 no second frame", {31'd0, ser_valid}, 32'd0);
            end
        end
        f_alarm = pay[47:32];
        f_cv    = pay[31:16];
        f_sel   = pay[15:0];
    endtask

    task automatic pulse_window();
        sec_pulse = 1'b1;
        @(negedge clk);
        sec_pulse = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R11 ser_valid", {31'd0, ser_valid}, 32'd0);
        check("R11 ser_out", {31'd0, ser_out}, 32'd0);
        check("R11 urgent_req", {31'd0, urgent_req}, 32'd0);
        check("R11 R5 ctrl outputs", {29'd0, led_on, prot_sel, inject_force}, 32'd0);
        poll_frame(1'b0);
        check("R11 alarm word", {16'd0, f_alarm}, 32'd0);
        check("R11 cv count", {16'd0, f_cv}, 32'd0);
        check("R11 sel count", {16'd0, f_sel}, 32'd0);
    endtask

    task automatic t_latch();
        do_reset();
        alarm_in[9] = 1'b1; alarm_in[12] = 1'b1;
        @(negedge clk);
        alarm_in[9] = 1'b0;
        repeat (3) @(negedge clk);
        poll_frame(1'b0);
        check("R1 sticky pulse reported", {16'd0, f_alarm}, 32'h1200);
        poll_frame(1'b0);
        check("R2 cleared inactive, kept active", {16'd0, f_alarm}, 32'h1000);
        alarm_in[12] = 1'b0;
        @(negedge clk);
        poll_frame(1'b0);
        check("R1 latch holds after drop", {16'd0, f_alarm}, 32'h1000);
        poll_frame(1'b0);
        check("R2 cleared after poll", {16'd0, f_alarm}, 32'h0000);
    endtask

    task automatic t_repoll();
        do_reset();
        alarm_in[4] = 1'b1;
        @(negedge clk);
        alarm_in[4] = 1'b0;
        poll_frame(1'b1);
        check("R4 frame content intact", {16'd0, f_alarm}, 32'h0010);
    endtask

    task automatic t_ctrl();
        do_reset();
        ctrl_we = 1'b1; ctrl_wdata = 3'b101;
        @(negedge clk);
        ctrl_we = 1'b0; ctrl_wdata = 3'b010;
        check("R5 write 101", {29'd0, led_on, prot_sel, inject_force}, 32'h5);
        repeat (2) @(negedge clk);
        check("R5 hold without strobe", {29'd0, led_on, prot_sel, inject_force}, 32'h5);
        ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
        check("R5 write 010", {29'd0, led_on, prot_sel, inject_force}, 32'h2);
    endtask

    task automatic t_urgent();
        do_reset();
        alarm_in[5] = 1'b1; alarm_in[15] = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 non-critical no request", {31'd0, urgent_req}, 32'd0);
        alarm_in[2] = 1'b1;
        @(negedge clk);
        check("R6 critical raises request", {31'd0, urgent_req}, 32'd1);
        repeat (3) @(negedge clk);
        check("R7 held without ack", {31'd0, urgent_req}, 32'd1);
        urgent_ack = 1'b1;
        @(negedge clk);
        urgent_ack = 1'b0;
        check("R7 ack clears", {31'd0, urgent_req}, 32'd0);
        repeat (2) @(negedge clk);
        check("R7 level alarm does not re-raise", {31'd0, urgent_req}, 32'd0);
        alarm_in[3] = 1'b1;
        @(negedge clk);
        check("R6 bit3 raises", {31'd0, urgent_req}, 32'd1);
        urgent_ack = 1'b1; alarm_in[0] = 1'b1;
        @(negedge clk);
        urgent_ack = 1'b0;
        check("R8 new alarm with ack keeps request", {31'd0, urgent_req}, 32'd1);
        urgent_ack = 1'b1;
        @(negedge clk);
        urgent_ack = 1'b0;
        check("R7 second ack clears", {31'd0, urgent_req}, 32'd0);
    endtask

    task automatic t_counts();
        do_reset();
        err_src_sel = 1'b0;
        for (int i = 0; i < 7; i++) begin
            cv_err = (i < 5); par_err = (i < 3); cum_err = 1'b1;
            @(negedge clk);
        end
        cv_err = 0; par_err = 0; cum_err = 0;
        pulse_window();
        poll_frame(1'b0);
        check("R9 cv count", {16'd0, f_cv}, 32'd5);
        check("R9 parity selected", {16'd0, f_sel}, 32'd3);
        err_src_sel = 1'b1;
        for (int i = 0; i < 4; i++) begin
            cum_err = 1'b1; par_err = (i < 2);
            @(negedge clk);
        end
        cum_err = 0; par_err = 0;
        cv_err = 1'b1;
        pulse_window();
        cv_err = 1'b0;
        poll_frame(1'b0);
        check("R9 cv window restart", {16'd0, f_cv}, 32'd0);
        check("R9 cumulative selected", {16'd0, f_sel}, 32'd4);
        pulse_window();
        poll_frame(1'b0);
        check("R9 edge event in new window", {16'd0, f_cv}, 32'd1);
    endtask

    task automatic t_saturate();
        do_reset();
        err_src_sel = 1'b0;
        cv_err = 1'b1; par_err = 1'b1;
        repeat (65540) @(negedge clk);
        cv_err = 1'b0; par_err = 1'b0;
        pulse_window();
        poll_frame(1'b0);
        check("R10 cv saturates", {16'd0, f_cv}, 32'hFFFF);
        check("R10 sel saturates", {16'd0, f_sel}, 32'hFFFF);
    endtask

    initial begin
        t_reset_state();
        t_latch();
        t_repoll();
        t_ctrl();
        t_urgent();
        t_counts();
        t_saturate();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule